// File: doc/BRIEF.md
# Converter Frame Reader (Serial Host Side)

This block is the host end of a four-wire serial link to a multichannel delta-sigma converter. It waits for the converter's active-low data-ready line to fall. It then pulls chip select low and clocks out one whole conversion frame: a 24-bit status word followed by eight 24-bit channel samples. Each word is handed to the rest of the chip on a parallel bus, with a one-cycle valid strobe and a word index.

Two retrieval modes are selected by `contMode`. In continuous mode the converter streams the frame as soon as it is clocked, so no command is sent. In on-demand mode every frame is preceded by an 8-bit read command shifted out MSB first. After the last serial clock the block keeps chip select low for a programmable number of master-clock cycles and then raises it. Raising chip select resets the converter's serial port, so every frame starts from a clean interface. A data-ready event that arrives while a frame is still being drained is reported on a one-cycle overrun flag. That event is not serviced.

Top module: `frame_reader_host`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `csN` is 1 and `sclk`, `mosiLine`, `wordValid` and `overrun` are 0.
- R2: A 1-to-0 transition on `drdyN` seen while no frame is active drives `csN` low on the next clock edge.
- R3: `sclk` idles at 0 and is never 1 while `csN` is 1. Within a frame, consecutive rising edges of `sclk` are exactly 2*SCLK_HALF clock cycles apart.
- R4: With `contMode`=1 the frame has exactly 216 `sclk` pulses and `mosiLine` stays 0 throughout.
- R5: With `contMode`=0 the frame has exactly 224 `sclk` pulses. The first 8 carry CMD_CODE (default 8'h12) MSB first on `mosiLine`. `mosiLine` changes only on a rising `sclk` edge and stays 0 after the command.
- R6: `misoLine` is sampled on each falling `sclk` edge that follows the command bits. Bits are packed MSB first into 24-bit words, so the first data bit becomes bit 23 of word 0.
- R7: Each frame yields exactly 9 words on `wordData`. `wordIdx` runs 0 (status) to 8 (channel 8) in order, and each `wordValid` lasts one cycle.
- R8: `csN` rises no sooner than CS_HOLD clock cycles after the last falling `sclk` edge of a frame.
- R9: A falling `drdyN` during an active frame (including the hold) gives a one-cycle pulse on `overrun`. The frame in progress still completes, and that event starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock, also the block clock |
| rstN | input | 1 | Active-low synchronous reset |
| contMode | input | 1 | 1 = continuous streaming, 0 = send read command per frame |
| drdyN | input | 1 | Active-low data-ready from the converter |
| misoLine | input | 1 | Serial data returned by the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosiLine | output | 1 | Serial command line to the converter |
| wordData | output | 24 | Assembled status or channel word |
| wordIdx | output | 4 | Index of the word on `wordData`, 0 = status |
| wordValid | output | 1 | One-cycle strobe marking a new word |
| overrun | output | 1 | One-cycle pulse when data-ready falls mid-frame |

## Verification
A bit counter that drifts shows up as a wrong `sclk` pulse count when `csN` rises. It also misaligns every word after the fault, so the next `wordValid` carries a shifted value or the wrong index, within 24 serial clocks. A command register loaded with the wrong value shows up as a bad `mosiLine` bit within the first eight pulses. A hold counter that ends early shows up on the very rising edge of `csN`. A stuck frame-active state appears either as a missing `csN` rise or as a frame started by an event that should only have raised `overrun`.

// File: rtl/frh_pkg.sv
package frh_pkg;
  // Per-cycle strobes from the sequencer to the shift datapath.
  typedef struct packed {
    logic start;     // frame begins this cycle
    logic riseEdge;  // sclk goes high at this edge
    logic fallEdge;  // sclk goes low at this edge
    logic dataBit;   // current serial bit belongs to the returned frame
  } frh_strobe_t;
endpackage

// File: rtl/frh_ctrl.sv
module frh_ctrl
  import frh_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int CS_HOLD   = 4,
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 216
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        drdyN,
  input  logic        contMode,
  output logic        csN,
  output logic        sclk,
  output logic        overrun,
  output frh_strobe_t strb
);
  localparam int BIT_W  = $clog2(CMD_BITS + DATA_BITS + 1);
  localparam int HALF_W = $clog2(SCLK_HALF + 1);
  localparam int HOLD_W = $clog2(CS_HOLD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} ctrl_state_t;

  ctrl_state_t       state;
  logic              drdyPrev;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  cmdLen;
  logic [HOLD_W-1:0] holdCnt;
  logic              drdyFall;
  logic              halfWrap;
  logic              lastBit;

  always_comb begin
    drdyFall      = drdyPrev & ~drdyN;
    halfWrap      = (halfCnt == HALF_W'(SCLK_HALF - 1));
    lastBit       = (bitCnt == cmdLen + BIT_W'(DATA_BITS - 1));
    strb.start    = (state == ST_IDLE) && drdyFall;
    strb.riseEdge = (state == ST_SHIFT) && halfWrap && !sclk;
    strb.fallEdge = (state == ST_SHIFT) && halfWrap && sclk;
    strb.dataBit  = (bitCnt >= cmdLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      drdyPrev <= 1'b1;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      overrun  <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      cmdLen   <= '0;
      holdCnt  <= '0;
    end else begin
      drdyPrev <= drdyN;
      overrun  <= drdyFall && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (strb.start) begin
            csN     <= 1'b0;
            state   <= ST_SHIFT;
            halfCnt <= '0;
            bitCnt  <= '0;
            cmdLen  <= contMode ? '0 : BIT_W'(CMD_BITS);
          end
        end
        ST_SHIFT: begin
          halfCnt <= halfWrap ? '0 : halfCnt + 1'b1;
          if (halfWrap) sclk <= ~sclk;
          if (strb.fallEdge) begin
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) begin
              state   <= ST_HOLD;
              holdCnt <= '0;
            end
          end
        end
        ST_HOLD: begin
          if (holdCnt == HOLD_W'(CS_HOLD - 1)) begin
            csN   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frh_datapath.sv
module frh_datapath
  import frh_pkg::*;
#(
  parameter int                WORD_W    = 24,
  parameter int                NUM_WORDS = 9,
  parameter int                CMD_BITS  = 8,
  parameter int                IDX_W     = 4,
  parameter logic [CMD_BITS-1:0] CMD_CODE = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              contMode,
  input  frh_strobe_t       strb,
  input  logic              misoLine,
  output logic              mosiLine,
  output logic [WORD_W-1:0] wordData,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              wordValid
);
  localparam int BITW_W = $clog2(WORD_W);

  logic [CMD_BITS-1:0] cmdShift;
  logic [WORD_W-1:0]   rxShift;
  logic [WORD_W-1:0]   rxNext;
  logic [BITW_W-1:0]   bitInWord;
  logic [IDX_W-1:0]    wordCnt;
  logic                wordDone;

  always_comb begin
    rxNext   = {rxShift[WORD_W-2:0], misoLine};
    wordDone = (bitInWord == BITW_W'(WORD_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdShift  <= '0;
      rxShift   <= '0;
      bitInWord <= '0;
      wordCnt   <= '0;
      mosiLine  <= 1'b0;
      wordData  <= '0;
      wordIdx   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (strb.start) begin
        cmdShift  <= contMode ? '0 : CMD_CODE;
        mosiLine  <= 1'b0;
        bitInWord <= '0;
        wordCnt   <= '0;
      end
      if (strb.riseEdge) begin
        mosiLine <= cmdShift[CMD_BITS-1];
        cmdShift <= {cmdShift[CMD_BITS-2:0], 1'b0};
      end
      if (strb.fallEdge && strb.dataBit) begin
        rxShift <= rxNext;
        if (wordDone) begin
          bitInWord <= '0;
          wordData  <= rxNext;
          wordIdx   <= wordCnt;
          wordValid <= 1'b1;
          wordCnt   <= wordCnt + 1'b1;
        end else begin
          bitInWord <= bitInWord + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_reader_host.sv
module frame_reader_host
  import frh_pkg::*;
#(
  parameter int         WORD_W    = 24,
  parameter int         NUM_CH    = 8,
  parameter int         SCLK_HALF = 2,
  parameter int         CS_HOLD   = 4,
  parameter logic [7:0] CMD_CODE  = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              contMode,
  input  logic              drdyN,
  input  logic              misoLine,
  output logic              csN,
  output logic              sclk,
  output logic              mosiLine,
  output logic [WORD_W-1:0] wordData,
  output logic [$clog2(NUM_CH+1)-1:0] wordIdx,
  output logic              wordValid,
  output logic              overrun
);
  localparam int NUM_WORDS = NUM_CH + 1;
  localparam int DATA_BITS = WORD_W * NUM_WORDS;
  localparam int CMD_BITS  = 8;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  frh_strobe_t strb;

  frh_ctrl #(
    .SCLK_HALF(SCLK_HALF), .CS_HOLD(CS_HOLD),
    .CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .contMode(contMode),
    .csN(csN), .sclk(sclk), .overrun(overrun), .strb(strb)
  );

  frh_datapath #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .CMD_BITS(CMD_BITS),
    .IDX_W(IDX_W), .CMD_CODE(CMD_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .contMode(contMode), .strb(strb),
    .misoLine(misoLine), .mosiLine(mosiLine), .wordData(wordData),
    .wordIdx(wordIdx), .wordValid(wordValid)
  );
endmodule

// File: rtl/frh_checker.sv
module frh_checker #(
  parameter int CS_HOLD   = 4,
  parameter int NUM_WORDS = 9,
  parameter int IDX_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sclk,
  input logic             mosiLine,
  input logic             wordValid,
  input logic [IDX_W-1:0] wordIdx,
  input logic             overrun
);
  localparam int GAP_W = $clog2(CS_HOLD + 1);

  logic             sclkQ;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      gapCnt <= '0;
    end else begin
      sclkQ <= sclk;
      if (sclkQ && !sclk) gapCnt <= GAP_W'(1);
      else if (gapCnt != GAP_W'(CS_HOLD)) gapCnt <= gapCnt + 1'b1;
    end
  end

  // R3
  cs_low_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosiLine));
  // R7
  word_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordIdx < IDX_W'(NUM_WORDS)));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  // R8
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (gapCnt >= GAP_W'(CS_HOLD)));
  // R9
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> !overrun);
  // R9
  overrun_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !$past(csN));
endmodule

bind frame_reader_host frh_checker #(
  .CS_HOLD(CS_HOLD), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosiLine(mosiLine),
  .wordValid(wordValid), .wordIdx(wordIdx), .overrun(overrun)
);

// File: tb/frame_reader_host_bench.sv
module frame_reader_host_bench;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 2;
  localparam int         HOLD       = 4;
  localparam logic [7:0] CMD        = 8'h12;
  localparam int         NWORDS     = 9;
  // stimulus table: {contMode, seed}; expected words derive from the seed
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 24'h000000}, {1'b1, 24'hFFFFFF}, {1'b0, 24'h3A5C17},
    {1'b1, 24'h81F00D}, {1'b0, 24'hFFFFFF}, {1'b0, 24'h000000}
  };

  logic clk = 1'b0, rstN = 1'b0, contMode = 1'b1, drdyN = 1'b1, misoLine = 1'b0;
  logic csN, sclk, mosiLine, wordValid, overrun;
  logic [23:0] wordData;
  logic [3:0]  wordIdx;

  frame_reader_host #(.SCLK_HALF(HALF), .CS_HOLD(HOLD), .CMD_CODE(CMD)) u_frame_reader_host (
    .clk(clk), .rstN(rstN), .contMode(contMode), .drdyN(drdyN), .misoLine(misoLine),
    .csN(csN), .sclk(sclk), .mosiLine(mosiLine), .wordData(wordData),
    .wordIdx(wordIdx), .wordValid(wordValid), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, monChecks = 0, monFails = 0;
  int framesDone = 0, frameStarts = 0;
  logic curCont = 1'b1;
  logic [23:0] expWord [NWORDS];

  function automatic logic [23:0] wordOf(logic [23:0] seed, int i);
    logic [23:0] v;
    if (seed == 24'h000000) return 24'h000000;
    if (seed == 24'hFFFFFF) return 24'hFFFFFF;
    v = seed + 24'(i) * 24'h2D4E1B;
    return v ^ {v[11:0], v[23:12]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and port monitor, sampled away from the active edge
  logic sclkP = 1'b0, csP = 1'b1, validP = 1'b0, mosiHigh = 1'b0;
  logic [7:0] cmdCap = 8'h00;
  int cyc = 0, riseCnt = 0, fallCnt = 0, lastFall = 0, lastRise = -1, wordsSeen = 0;

  task automatic mchk(input bit ok, input string req, input int act, input int exp);
    monChecks++;
    if (!ok) begin
      monFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      int cmdBits;
      int k;
      cmdBits = curCont ? 0 : 8;
      cyc++;
      if (csP && !csN) begin
        frameStarts++;
        riseCnt = 0; fallCnt = 0; cmdCap = 8'h00; mosiHigh = 1'b0;
        wordsSeen = 0; lastRise = -1;
      end
      if (csN && sclk) mchk(1'b0, "R3 sclk high with csN high", 1, 0);
      if (!sclkP && sclk) begin
        if (lastRise >= 0) mchk(cyc - lastRise == 2*HALF, "R3 sclk period", cyc - lastRise, 2*HALF);
        lastRise = cyc;
        k = riseCnt - cmdBits;
        if (k >= 0 && k < 24*NWORDS) misoLine = expWord[k/24][23 - (k%24)];
        else misoLine = 1'b0;
        riseCnt++;
      end
      if (sclkP && !sclk) begin
        fallCnt++;
        lastFall = cyc;
        if (!curCont && fallCnt <= 8) cmdCap = {cmdCap[6:0], mosiLine};
        else if (mosiLine) mosiHigh = 1'b1;
      end
      if (wordValid) begin
        mchk(validP == 1'b0, "R7 valid longer than one cycle", 1, 0);
        mchk(int'(wordIdx) == wordsSeen, "R7 word index", wordIdx, wordsSeen);
        if (wordsSeen < NWORDS)
          mchk(wordData == expWord[wordsSeen], "R6 word value", wordData, expWord[wordsSeen]);
        wordsSeen++;
      end
      if (!csP && csN) begin
        mchk(cyc - lastFall >= HOLD, "R8 cs hold", cyc - lastFall, HOLD);
        if (curCont) begin
          mchk(riseCnt == 216, "R4 sclk pulse count", riseCnt, 216);
          mchk(!mosiHigh, "R4 mosi idle", mosiHigh, 0);
        end else begin
          mchk(riseCnt == 224, "R5 sclk pulse count", riseCnt, 224);
          mchk(cmdCap == CMD, "R5 command byte", cmdCap, CMD);
          mchk(!mosiHigh, "R5 mosi low after command", mosiHigh, 0);
        end
        mchk(wordsSeen == NWORDS, "R7 words per frame", wordsSeen, NWORDS);
        framesDone++;
      end
      validP = wordValid;
      sclkP = sclk;
      csP = csN;
    end
  end

  task automatic runFrame(input logic cont, input logic [23:0] seed, input bit doOverrun);
    int d, s, n;
    @(negedge clk);
    curCont = cont;
    contMode = cont;
    for (int i = 0; i < NWORDS; i++) expWord[i] = wordOf(seed, i);
    d = framesDone;
    s = frameStarts;
    drdyN = 1'b0;
    @(negedge clk);
    chk(csN == 1'b0, "R2 csN low after drdy fall", csN, 0);
    repeat (3) @(negedge clk);
    drdyN = 1'b1;
    if (doOverrun) begin
      repeat (100) @(negedge clk);
      drdyN = 1'b0;
      @(negedge clk);
      chk(overrun == 1'b1, "R9 overrun pulse", overrun, 1);
      @(negedge clk);
      chk(overrun == 1'b0, "R9 overrun one cycle", overrun, 0);
    end
    n = 0;
    while (framesDone == d && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R2 frame completes", n, 5000);
    if (doOverrun) begin
      repeat (30) @(negedge clk);
      chk(csN == 1'b1 && frameStarts == s + 1, "R9 no extra frame", frameStarts - s, 1);
      drdyN = 1'b1;
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks + monChecks + 1, fails + monFails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(csN == 1'b1 && sclk == 1'b0 && mosiLine == 1'b0 && wordValid == 1'b0 && overrun == 1'b0,
        "R1 reset outputs", {csN, sclk, mosiLine, wordValid, overrun}, 5'b10000);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0 && mosiLine == 1'b0 && wordValid == 1'b0 && overrun == 1'b0,
        "R1 first cycle after reset", {csN, sclk, mosiLine, wordValid, overrun}, 5'b10000);
    for (int v = 0; v < 6; v++) runFrame(VEC[v][24], VEC[v][23:0], 1'b0);
    // R9 overrun in each mode, then a normal frame right after
    runFrame(1'b0, 24'h5A17C3, 1'b1);
    runFrame(1'b1, 24'hC0FFEE, 1'b1);
    runFrame(1'b1, 24'h123456, 1'b0);
    chk(frameStarts == 9 && framesDone == 9, "R2 frame count", frameStarts, 9);
    $display("  [TB] %0d tests run, %0d failed", checks + monChecks, fails + monFails);
    $finish;
  end
endmodule